// File: doc/BRIEF.md
# Associative Rename Buffer Array

This block holds a small pool of rename buffers for an out-of-order core. There is no separate mapping table. Each entry remembers which architectural register it stands for and whether it is the newest copy of that register. An issuing instruction with a destination is given the lowest free entry. That entry becomes the newest copy of the register, and any older copy of the same register loses its newest mark in the same cycle. When execution finishes, a result write stores the value and marks the entry ready.

To rename a source operand, the caller presents an architectural register number. Every entry compares its stored register number against the request at once. The single valid entry that matches and carries the newest mark is the hit. If no entry matches, the result is a miss, and the caller then reads the operand from the architectural file. Release frees one entry. Flush empties the whole pool. The value storage has a synchronous read port, so it can map to on-chip block memory.

Top module: `rbuf_assoc_array`

## Requirements
- R1: After reset no entry is valid, so every lookup misses.
- R2: `alloc_ok` is high exactly when at least one entry is free, and `alloc_idx` then shows the lowest-numbered free entry. An allocation request with `alloc_ok` high claims that entry at the clock edge. An allocation request while all entries are valid changes nothing.
- R3: A lookup request reports, one cycle later, `lk_hit`=1 and the index of the valid entry whose register matches and which holds the newest mark.
- R4: Allocating register r clears the newest mark on every older valid entry for r in the same edge, so lookups of r return the new entry. At most one valid entry per register ever holds the newest mark.
- R5: After allocation an entry reads `lk_rdy`=0. Once a result write to that valid entry has taken effect, lookups return `lk_rdy`=1 with `lk_data` equal to the written value.
- R6: A result write aimed at an entry that is not valid is ignored. An entry allocated later still reads `lk_rdy`=0.
- R7: Releasing the entry that holds the newest mark for r makes later lookups of r miss, even if older entries for r remain valid. Releasing a valid entry makes it free from the next cycle on.
- R8: Releasing an entry that does not hold the newest mark leaves lookups of its register unchanged.
- R9: Flush empties the pool at the edge and takes priority over any same-cycle allocation. Afterwards lookups miss and `alloc_idx` is 0.
- R10: A lookup sees the pool as it was before the same edge's allocation, release, write or flush.
- R11: A reallocated entry starts not ready, even if it held a ready result before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Allocation request |
| alloc_areg | input | AREG_W | Destination architectural register |
| alloc_ok | output | 1 | A free entry exists |
| alloc_idx | output | IDX_W | Entry that an allocation would claim |
| wr_en | input | 1 | Result write request |
| wr_idx | input | IDX_W | Entry receiving the result |
| wr_data | input | DATA_W | Result value |
| lk_en | input | 1 | Source lookup request |
| lk_areg | input | AREG_W | Source architectural register |
| lk_hit | output | 1 | Lookup found a newest valid entry (registered) |
| lk_idx | output | IDX_W | Index of that entry (registered) |
| lk_rdy | output | 1 | That entry holds its result (registered) |
| lk_data | output | DATA_W | Result value, meaningful when lk_rdy is high |
| rel_en | input | 1 | Release request |
| rel_idx | input | IDX_W | Entry to release |
| flush | input | 1 | Invalidate every entry |

## Verification
`alloc_ok` and `alloc_idx` come straight from the entry state, so they are compared in the same cycle, before any stimulus is applied. Allocation, release, write and flush change state at the next rising edge. Lookup results are registered, and the data also passes through the synchronous memory read, so all of them appear after that same edge. The bench drives inputs on falling edges and compares lookup results on the following falling edge. It predicts each result from a model of the pool as it stood before the edge, which enforces the pre-update view of R10. A long pseudo-random sweep over four registers and eight entries forces frequent same-register collisions, full pools, stray writes and flushes.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  typedef struct packed {
    logic valid;
    logic latest;
    logic ready;
  } rb_flags_t;
endpackage

// File: rtl/rbuf_free_pick.sv
module rbuf_free_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  used,
  output logic          any_free,
  output logic [IW-1:0] idx
);
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used[i]) begin
        any_free = 1'b1;
        idx      = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rbuf_cam.sv
module rbuf_cam #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int AW = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        valid,
  input  logic [N-1:0]        latest,
  input  logic [N-1:0][AW-1:0] areg,
  input  logic [AW-1:0]       key,
  output logic                hit,
  output logic [IW-1:0]       idx
);
  logic [N-1:0] match_vec;

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match_vec[g] = valid[g] && latest[g] && (areg[g] == key);
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  AST_ONE_LATEST: assert property (@(posedge clk) disable iff (rst) $onehot0(match_vec)); // R4
endmodule

// File: rtl/rbuf_values.sv
module rbuf_values #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rbuf_assoc_array.sv
module rbuf_assoc_array #(
  parameter int NUM_ENTRIES = 8,
  parameter int AREG_W      = 5,
  parameter int DATA_W      = 16,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [AREG_W-1:0] alloc_areg,
  output logic              alloc_ok,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lk_en,
  input  logic [AREG_W-1:0] lk_areg,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              lk_rdy,
  output logic [DATA_W-1:0] lk_data,
  input  logic              rel_en,
  input  logic [IDX_W-1:0]  rel_idx,
  input  logic              flush
);
  import rbuf_pkg::*;

  rb_flags_t [NUM_ENTRIES-1:0]             flg_q;
  logic      [NUM_ENTRIES-1:0][AREG_W-1:0] areg_q;
  logic      [NUM_ENTRIES-1:0]             valid_q;
  logic      [NUM_ENTRIES-1:0]             latest_q;
  logic      [NUM_ENTRIES-1:0]             ready_q;

  generate
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_unpack
      assign valid_q[g]  = flg_q[g].valid;
      assign latest_q[g] = flg_q[g].latest;
      assign ready_q[g]  = flg_q[g].ready;
    end
  endgenerate

  logic             any_free;
  logic [IDX_W-1:0] free_idx;

  rbuf_free_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) i_pick (
    .used     (valid_q),
    .any_free (any_free),
    .idx      (free_idx)
  );

  assign alloc_ok  = any_free;
  assign alloc_idx = free_idx;

  logic do_alloc;
  logic do_rel;
  logic do_wr;
  assign do_alloc = alloc_en && any_free && !flush;
  assign do_rel   = rel_en && valid_q[rel_idx] && !flush;
  assign do_wr    = wr_en && valid_q[wr_idx] && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < NUM_ENTRIES; i++) flg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (do_alloc && free_idx == IDX_W'(i)) begin
          flg_q[i].valid  <= 1'b1;
          flg_q[i].latest <= 1'b1;
          flg_q[i].ready  <= 1'b0;
          areg_q[i]       <= alloc_areg;
        end else if (do_rel && rel_idx == IDX_W'(i)) begin
          flg_q[i].valid  <= 1'b0;
          flg_q[i].latest <= 1'b0;
        end else begin
          if (do_wr && wr_idx == IDX_W'(i)) flg_q[i].ready <= 1'b1;
          if (do_alloc && valid_q[i] && areg_q[i] == alloc_areg) flg_q[i].latest <= 1'b0;
        end
      end
    end
  end

  logic             cam_hit;
  logic [IDX_W-1:0] cam_idx;

  rbuf_cam #(.N(NUM_ENTRIES), .IW(IDX_W), .AW(AREG_W)) i_cam (
    .clk    (clk),
    .rst    (rst),
    .valid  (valid_q),
    .latest (latest_q),
    .areg   (areg_q),
    .key    (lk_areg),
    .hit    (cam_hit),
    .idx    (cam_idx)
  );

  rbuf_values #(.N(NUM_ENTRIES), .IW(IDX_W), .DW(DATA_W)) i_vals (
    .clk   (clk),
    .we    (do_wr),
    .waddr (wr_idx),
    .wdata (wr_data),
    .raddr (cam_idx),
    .rdata (lk_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit <= 1'b0;
      lk_idx <= '0;
      lk_rdy <= 1'b0;
    end else begin
      lk_hit <= lk_en && cam_hit;
      lk_idx <= cam_idx;
      lk_rdy <= lk_en && cam_hit && ready_q[cam_idx];
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && !alloc_ok && !rel_en && !flush) |=> (valid_q == $past(valid_q))); // R2
  AST_REL_FREES: assert property (@(posedge clk) disable iff (rst)
    (rel_en && valid_q[rel_idx] && !flush) |=> !valid_q[$past(rel_idx)]); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0)); // R9
  AST_WRITE_READY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && valid_q[wr_idx] && !flush && !(rel_en && rel_idx == wr_idx))
      |=> ready_q[$past(wr_idx)]); // R5
  AST_HIT_REQ: assert property (@(posedge clk) disable iff (rst)
    !lk_en |=> !lk_hit); // R3
endmodule

// File: tb/test_rbuf_assoc_array.sv
module test_rbuf_assoc_array;
  localparam int N  = 8;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_en = 0; logic [AW-1:0] alloc_areg = '0;
  logic alloc_ok; logic [IW-1:0] alloc_idx;
  logic wr_en = 0; logic [IW-1:0] wr_idx = '0; logic [DW-1:0] wr_data = '0;
  logic lk_en = 0; logic [AW-1:0] lk_areg = '0;
  logic lk_hit; logic [IW-1:0] lk_idx; logic lk_rdy; logic [DW-1:0] lk_data;
  logic rel_en = 0; logic [IW-1:0] rel_idx = '0;
  logic flush = 0;

  always #10 clk = ~clk;

  rbuf_assoc_array #(.NUM_ENTRIES(N), .AREG_W(AW), .DATA_W(DW)) i_rbuf_assoc_array (
    .clk(clk), .rst(rst), .alloc_en(alloc_en), .alloc_areg(alloc_areg),
    .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .lk_en(lk_en), .lk_areg(lk_areg), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_rdy(lk_rdy), .lk_data(lk_data), .rel_en(rel_en),
    .rel_idx(rel_idx), .flush(flush)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit mv [N]; bit ml [N]; bit mk [N]; int mr [N]; logic [DW-1:0] md [N];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit ae, input int ar, input bit we, input int wi,
                      input logic [DW-1:0] wd, input bit le, input int lr, input bit re,
                      input int ri, input bit fl);
    int fi = -1;
    bit eh = 0;
    int ei = 0;
    for (int i = N - 1; i >= 0; i--) if (!mv[i]) fi = i;
    chk(alloc_ok === (fi >= 0), "R2 alloc_ok", 32'(alloc_ok), 32'(fi >= 0));
    if (fi >= 0) chk(alloc_idx === IW'(fi), "R2 alloc_idx", 32'(alloc_idx), 32'(fi));
    for (int i = 0; i < N; i++) if (mv[i] && ml[i] && mr[i] == lr) begin eh = 1; ei = i; end
    alloc_en = ae; alloc_areg = AW'(ar); wr_en = we; wr_idx = IW'(wi); wr_data = wd;
    lk_en = le; lk_areg = AW'(lr); rel_en = re; rel_idx = IW'(ri); flush = fl;
    @(negedge clk);
    alloc_en = 0; wr_en = 0; lk_en = 0; rel_en = 0; flush = 0;
    if (le) begin
      chk(lk_hit === eh, {tag, " hit"}, 32'(lk_hit), 32'(eh));
      if (eh) begin
        chk(lk_idx === IW'(ei), {tag, " idx"}, 32'(lk_idx), 32'(ei));
        chk(lk_rdy === mk[ei], {tag, " rdy"}, 32'(lk_rdy), 32'(mk[ei]));
        if (mk[ei]) chk(lk_data === md[ei], {tag, " data"}, 32'(lk_data), 32'(md[ei]));
      end
    end
    if (fl) begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; ml[i] = 0; mk[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ae && fi == i) begin
          mv[i] = 1; ml[i] = 1; mk[i] = 0; mr[i] = ar;
        end else if (re && ri == i && mv[i]) begin
          mv[i] = 0; ml[i] = 0;
        end else begin
          if (we && wi == i && mv[i]) begin mk[i] = 1; md[i] = wd; end
          if (ae && fi >= 0 && mv[i] && mr[i] == ar) ml[i] = 0;
        end
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] x = 32'h1234_5678;
    for (int i = 0; i < N; i++) begin mv[i] = 0; ml[i] = 0; mk[i] = 0; mr[i] = 0; md[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    step("R1",  0, 0,  0, 0, 0,      1, 3,  0, 0, 0);
    step("R10", 1, 3,  0, 0, 0,      1, 3,  0, 0, 0);
    step("R3",  1, 5,  0, 0, 0,      1, 3,  0, 0, 0);
    step("R10", 1, 3,  0, 0, 0,      1, 3,  0, 0, 0);
    step("R4",  0, 0,  0, 0, 0,      1, 3,  0, 0, 0);
    step("R5",  0, 0,  1, 2, 16'hBEEF, 1, 3, 0, 0, 0);
    step("R5",  0, 0,  0, 0, 0,      1, 3,  0, 0, 0);
    step("R6",  0, 0,  1, 6, 16'h1234, 1, 5, 0, 0, 0);
    step("R2",  1, 7,  0, 0, 0,      0, 0,  0, 0, 0);
    step("R2",  1, 8,  0, 0, 0,      0, 0,  0, 0, 0);
    step("R2",  1, 9,  0, 0, 0,      0, 0,  0, 0, 0);
    step("R2",  1, 10, 0, 0, 0,      0, 0,  0, 0, 0);
    step("R6",  0, 0,  0, 0, 0,      1, 10, 0, 0, 0);
    step("R2",  1, 11, 0, 0, 0,      0, 0,  0, 0, 0);
    step("R2",  1, 3,  0, 0, 0,      1, 3,  0, 0, 0);
    step("R2",  0, 0,  0, 0, 0,      1, 3,  0, 0, 0);
    step("R7",  0, 0,  0, 0, 0,      0, 0,  1, 2, 0);
    step("R7",  0, 0,  0, 0, 0,      1, 3,  0, 0, 0);
    step("R8",  1, 5,  0, 0, 0,      0, 0,  0, 0, 0);
    step("R8",  0, 0,  0, 0, 0,      0, 0,  1, 1, 0);
    step("R8",  0, 0,  0, 0, 0,      1, 5,  0, 0, 0);
    step("R11", 0, 0,  1, 3, 16'h0077, 0, 0, 0, 0, 0);
    step("R11", 0, 0,  0, 0, 0,      1, 7,  1, 3, 0);
    step("R11", 1, 12, 0, 0, 0,      0, 0,  0, 0, 0);
    step("R11", 1, 13, 0, 0, 0,      0, 0,  0, 0, 0);
    step("R11", 0, 0,  0, 0, 0,      1, 13, 0, 0, 0);
    step("R9",  1, 4,  0, 0, 0,      1, 13, 0, 0, 1);
    step("R9",  0, 0,  0, 0, 0,      1, 13, 0, 0, 0);
    step("R9",  0, 0,  0, 0, 0,      1, 4,  0, 0, 0);
    for (int k = 0; k < 4000; k++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      step("R3 sweep", x[0] | x[1], int'(x[4:3]), x[5], int'(x[8:6]), x[31:16],
           1'b1, int'(x[10:9]), x[11] & x[12], int'(x[15:13]), x[22:16] == 7'd0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule